// File: doc/BRIEF.md
# Programming-Mode Entry and Command Sequencer

This block sits on the host side of a programmer for a small one-time-programmable microcontroller. For every accepted request it runs one complete transaction. It raises the programming-voltage enable, then the core supply enable, and waits for the supply to settle. It then clocks out one command frame over a two-wire serial link made of a clock and a bidirectional data line. Depending on the command it appends a write payload with slow processing clocks, or turns the data line around and captures a response. It then powers the target down again in the reverse order. All supply gaps are fixed microsecond delays derived from the `TICKS_PER_US` parameter. The serial clock half-period and the slow-clock half-period are run-time inputs counted in system clocks.

A frame is not byte aligned. It holds `PRE_GROUPS` copies of the byte 0xA5, then the 8-bit command, then a `TRAIL_W`-bit trailer (default 0xAA1, 12 bits), all sent most significant bit first. The data line changes only while the clock is low, and the target samples it on the rising clock edge. Requests enter through a valid/ready pair: `req_ready` is high only while the sequencer is idle, a request transfers on a cycle where both are high, and `req_valid` has no effect at any other time. Nothing waits on the host after acceptance. Completion is a one-cycle `done` pulse, and `resp_data` holds the captured response.

Top module: `otp_prog_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the block is idle, and `busy` is its inverse. A request is accepted when `req_valid` and `req_ready` are both 1. `req_valid` asserted while busy starts no transaction and does not alter the command, payload or response length of the transaction in progress.
- R2: On acceptance `vpp_en` rises first. `vdd_en` rises 100 µs (100·TICKS_PER_US clocks) after `vpp_en`. `vdd_en` is never 1 while `vpp_en` is 0.
- R3: The data line is first driven (`dat_oe` rises, first frame bit on `dat_o`) 500 µs after `vdd_en` rises. `dat_oe` is never 1 while `vdd_en` is 0.
- R4: Every frame starts with the header, sent MSB first: PRE_GROUPS bytes of 0xA5, then the command byte, then the trailer 0xAA1 (44 bits with defaults). `dat_o` and `dat_oe` stay unchanged while `pclk` is high.
- R5: Each header and payload clock has a low phase and a high phase of `half_cyc` system clocks each, with a value of 0 treated as 1.
- R6: For commands 0x70 and 0x71 the header is followed by words 0..3 (word i on `req_words[14*i+13:14*i]`), 14 bits each, MSB first, then the 13-bit `req_addr`, MSB first. Then come SLOW_PULSES clock pulses with `dat_o` low, each phase `slow_half_cyc` clocks long.
- R7: For commands 0x60 and 0x61 with a nonzero `req_resp_len`, `dat_oe` falls right after the trailer and stays low for one `half_cyc` period before the first capture clock rises. `req_resp_len` bits are then captured, each sampled at the end of its clock-high phase. The first captured bit lands as the most significant bit of the right-aligned `resp_data`.
- R8: For all other commands, and for reads with `req_resp_len` = 0, no clock pulse follows the trailer.
- R9: `vdd_en` falls 100 µs after the last clock falling edge of the transaction, and `vpp_en` falls 250 µs after `vdd_en`.
- R10: `done` pulses for exactly one cycle, in the cycle in which `vpp_en` is first seen low. `resp_data` keeps its value until a later read starts capturing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_cmd | input | 8 | Command byte |
| req_words | input | WORDS*WORD_W | Write data words, word 0 in the low bits |
| req_addr | input | ADDR_W | Write address field |
| req_resp_len | input | $clog2(RESP_MAX+1) | Number of response bits for read commands |
| half_cyc | input | HALF_W | Serial clock half-period in system clocks |
| slow_half_cyc | input | HALF_W | Slow processing clock half-period in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| resp_data | output | RESP_MAX | Captured response, right aligned |
| vpp_en | output | 1 | Programming-voltage enable |
| vdd_en | output | 1 | Target supply enable |
| pclk | output | 1 | Serial clock to target |
| dat_o | output | 1 | Serial data to target |
| dat_oe | output | 1 | Data line drive enable (0 = released) |
| dat_i | input | 1 | Serial data from target |

## Verification
The assertions watch the supply ordering on every cycle: the core supply never on without the programming voltage, the data line never driven without the supply, and `vpp_en` never dropping while `vdd_en` is high. They also watch the data and drive enable staying still through each clock-high phase, the data line being released before any capture clock, `done` being a single-cycle pulse, and `req_ready` implying an unpowered target. The exact microsecond gaps, the bit content of header, payload and slow clocks, the captured response value, the turnaround length and the rejection of requests made while busy depend on the particular request and timing inputs, so only the directed scenarios can show them.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [1:0] {
    PH_TX   = 2'd0,
    PH_SLOW = 2'd1,
    PH_RX   = 2'd2
  } phy_mode_t;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_VPP    = 4'd1,
    S_VDD    = 4'd2,
    S_HDR    = 4'd3,
    S_WR     = 4'd4,
    S_SLOW   = 4'd5,
    S_RX     = 4'd6,
    S_HOLD   = 4'd7,
    S_VDDOFF = 4'd8
  } seq_state_t;

  localparam logic [7:0] PRE_BYTE = 8'hA5;

  function automatic logic cmd_is_write(input logic [7:0] c);
    return (c == 8'h70) || (c == 8'h71);
  endfunction

  function automatic logic cmd_is_read(input logic [7:0] c);
    return (c == 8'h60) || (c == 8'h61);
  endfunction

endpackage

// File: rtl/otp_us_timer.sv
module otp_us_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt;
  logic          run;

  assign exp_o = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load_i) begin
      cnt <= val_i - 1'b1;
      run <= 1'b1;
    end else if (exp_o) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  a_r2_expiry_single: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_o && !load_i) |=> !exp_o);

endmodule

// File: rtl/otp_serial_phy.sv
module otp_serial_phy
  import otp_seq_pkg::*;
#(
  parameter int W        = 113,
  parameter int CW       = 8,
  parameter int HALF_W   = 16,
  parameter int RESP_MAX = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  phy_mode_t           mode_i,
  input  logic [CW-1:0]       nbits_i,
  input  logic [HALF_W-1:0]   half_i,
  input  logic [W-1:0]        vec_i,
  input  logic                dat_i,
  output logic                done_o,
  output logic                pclk_o,
  output logic                dat_o,
  output logic                dat_oe_o,
  output logic [RESP_MAX-1:0] rx_o
);
  logic                active, turn, hi;
  logic [HALF_W-1:0]   hcnt, hreload;
  logic [CW-1:0]       left;
  logic [W-1:0]        sh;
  logic [RESP_MAX-1:0] rx;
  phy_mode_t           mode_q;
  logic                tick;

  assign tick     = active && (hcnt == '0);
  assign done_o   = tick && !turn && hi && (left == CW'(1));
  assign pclk_o   = hi;
  assign dat_oe_o = active && (mode_q != PH_RX);
  assign dat_o    = active && (mode_q == PH_TX) && sh[W-1];
  assign rx_o     = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      turn    <= 1'b0;
      hi      <= 1'b0;
      hcnt    <= '0;
      hreload <= '0;
      left    <= '0;
      sh      <= '0;
      rx      <= '0;
      mode_q  <= PH_TX;
    end else begin
      if (active) begin
        if (hcnt != '0) begin
          hcnt <= hcnt - 1'b1;
        end else begin
          hcnt <= hreload;
          if (turn) begin
            turn <= 1'b0;
            hi   <= 1'b1;
          end else if (!hi) begin
            hi <= 1'b1;
          end else begin
            hi   <= 1'b0;
            sh   <= {sh[W-2:0], 1'b0};
            left <= left - 1'b1;
            if (mode_q == PH_RX) rx <= {rx[RESP_MAX-2:0], dat_i};
            if (left == CW'(1)) active <= 1'b0;
          end
        end
      end
      if (start_i) begin
        active  <= 1'b1;
        mode_q  <= mode_i;
        turn    <= (mode_i == PH_RX);
        hi      <= 1'b0;
        hcnt    <= half_i - 1'b1;
        hreload <= half_i - 1'b1;
        left    <= nbits_i;
        sh      <= vec_i;
        if (mode_i == PH_RX) rx <= '0;
      end
    end
  end

  // R4: line contents frozen while the clock is high
  a_r4_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_o && $past(pclk_o)) |-> ($stable(dat_o) && $stable(dat_oe_o)));

  // R7: a capture clock rises only after the line was already released
  a_r7_released_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pclk_o) && !dat_oe_o) |-> $past(!dat_oe_o));

  a_r5_clock_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_o |-> active);

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int               TICKS_PER_US = 24,
  parameter int               WORDS        = 4,
  parameter int               WORD_W       = 14,
  parameter int               ADDR_W       = 13,
  parameter int               PRE_GROUPS   = 3,
  parameter int               TRAIL_W      = 12,
  parameter logic [TRAIL_W-1:0] TRAIL      = 12'hAA1,
  parameter int               SLOW_PULSES  = 8,
  parameter int               RESP_MAX     = 64,
  parameter int               HALF_W       = 16,
  localparam int              LEN_W        = $clog2(RESP_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [7:0]               req_cmd,
  input  logic [WORDS*WORD_W-1:0]  req_words,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LEN_W-1:0]         req_resp_len,
  input  logic [HALF_W-1:0]        half_cyc,
  input  logic [HALF_W-1:0]        slow_half_cyc,
  output logic                     busy,
  output logic                     done,
  output logic [RESP_MAX-1:0]      resp_data,
  output logic                     vpp_en,
  output logic                     vdd_en,
  output logic                     pclk,
  output logic                     dat_o,
  output logic                     dat_oe,
  input  logic                     dat_i
);
  localparam int HDR_W     = 8 * PRE_GROUPS + 8 + TRAIL_W;
  localparam int PAY_W     = WORDS * WORD_W + ADDR_W;
  localparam int FRAME_W   = HDR_W + PAY_W;
  localparam int CW        = $clog2(FRAME_W + RESP_MAX + SLOW_PULSES + 1);
  localparam int D_VPP_VDD = 100 * TICKS_PER_US;
  localparam int D_VDD_CLK = 500 * TICKS_PER_US;
  localparam int D_END_VDD = 100 * TICKS_PER_US;
  localparam int D_VDD_VPP = 250 * TICKS_PER_US;
  localparam int TW        = $clog2(D_VDD_CLK + 1);

  seq_state_t          state, nxt;
  logic [7:0]          cmd_q;
  logic [PAY_W-1:0]    pay_w, pay_q;
  logic [LEN_W-1:0]    len_q;
  logic [HALF_W-1:0]   half_q, slow_q;
  logic                vpp_q, vdd_q, done_q;
  logic [HDR_W-1:0]    hdr;

  logic                phy_start, phy_done;
  phy_mode_t           phy_mode;
  logic [CW-1:0]       phy_n;
  logic [HALF_W-1:0]   phy_half;
  logic [FRAME_W-1:0]  phy_vec;
  logic                tmr_load, tmr_exp;
  logic [TW-1:0]       tmr_val;
  logic                accept;

  // payload: word 0 first, each MSB first, address last
  for (genvar i = 0; i < WORDS; i++) begin : g_pack
    assign pay_w[PAY_W-1-i*WORD_W -: WORD_W] = req_words[i*WORD_W +: WORD_W];
  end
  assign pay_w[ADDR_W-1:0] = req_addr;

  assign hdr       = {{PRE_GROUPS{PRE_BYTE}}, cmd_q, TRAIL};
  assign accept    = (state == S_IDLE) && req_valid;
  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign vpp_en    = vpp_q;
  assign vdd_en    = vdd_q;

  always_comb begin
    nxt       = state;
    phy_start = 1'b0;
    phy_mode  = PH_TX;
    phy_n     = '0;
    phy_half  = half_q;
    phy_vec   = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      S_IDLE: if (req_valid) begin
        tmr_load = 1'b1; tmr_val = TW'(D_VPP_VDD); nxt = S_VPP;
      end
      S_VPP: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_val = TW'(D_VDD_CLK); nxt = S_VDD;
      end
      S_VDD: if (tmr_exp) begin
        phy_start = 1'b1;
        if (cmd_is_write(cmd_q)) begin
          phy_n = CW'(FRAME_W); phy_vec = {hdr, pay_q}; nxt = S_WR;
        end else begin
          phy_n = CW'(HDR_W); phy_vec = {hdr, {PAY_W{1'b0}}}; nxt = S_HDR;
        end
      end
      S_HDR: if (phy_done) begin
        if (cmd_is_read(cmd_q) && (len_q != '0)) begin
          phy_start = 1'b1; phy_mode = PH_RX; phy_n = CW'(len_q); nxt = S_RX;
        end else begin
          tmr_load = 1'b1; tmr_val = TW'(D_END_VDD); nxt = S_HOLD;
        end
      end
      S_WR: if (phy_done) begin
        phy_start = 1'b1; phy_mode = PH_SLOW; phy_n = CW'(SLOW_PULSES);
        phy_half = slow_q; nxt = S_SLOW;
      end
      S_SLOW, S_RX: if (phy_done) begin
        tmr_load = 1'b1; tmr_val = TW'(D_END_VDD); nxt = S_HOLD;
      end
      S_HOLD: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_val = TW'(D_VDD_VPP); nxt = S_VDDOFF;
      end
      S_VDDOFF: if (tmr_exp) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cmd_q  <= '0;
      pay_q  <= '0;
      len_q  <= '0;
      half_q <= HALF_W'(1);
      slow_q <= HALF_W'(1);
      vpp_q  <= 1'b0;
      vdd_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state  <= nxt;
      done_q <= (state == S_VDDOFF) && tmr_exp;
      if (accept) begin
        cmd_q  <= req_cmd;
        pay_q  <= pay_w;
        len_q  <= (req_resp_len > LEN_W'(RESP_MAX)) ? LEN_W'(RESP_MAX) : req_resp_len;
        half_q <= (half_cyc == '0) ? HALF_W'(1) : half_cyc;
        slow_q <= (slow_half_cyc == '0) ? HALF_W'(1) : slow_half_cyc;
        vpp_q  <= 1'b1;
      end
      if ((state == S_VPP) && tmr_exp)    vdd_q <= 1'b1;
      if ((state == S_HOLD) && tmr_exp)   vdd_q <= 1'b0;
      if ((state == S_VDDOFF) && tmr_exp) vpp_q <= 1'b0;
    end
  end

  otp_us_timer #(.TW(TW)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .exp_o  (tmr_exp)
  );

  otp_serial_phy #(
    .W        (FRAME_W),
    .CW       (CW),
    .HALF_W   (HALF_W),
    .RESP_MAX (RESP_MAX)
  ) i_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (phy_start),
    .mode_i   (phy_mode),
    .nbits_i  (phy_n),
    .half_i   (phy_half),
    .vec_i    (phy_vec),
    .dat_i    (dat_i),
    .done_o   (phy_done),
    .pclk_o   (pclk),
    .dat_o    (dat_o),
    .dat_oe_o (dat_oe),
    .rx_o     (resp_data)
  );

  a_r2_vdd_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_en |-> vpp_en);

  a_r3_drive_needs_vdd: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> vdd_en);

  a_r1_ready_means_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!vpp_en && !dat_oe && !pclk));

  a_r9_vpp_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpp_en) |-> !vdd_en);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_with_vpp_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(vpp_en) && !busy));

endmodule

// File: tb/test_otp_prog_seq.sv
module test_otp_prog_seq;
  localparam int TPU = 4;
  localparam int D1 = 100 * TPU, D2 = 500 * TPU, D3 = 100 * TPU, D4 = 250 * TPU;
  localparam int HDR_N = 44, PAY_N = 4 * 14 + 13, SLOW_N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, dat_i = 1'b0;
  logic [7:0]  req_cmd = '0;
  logic [55:0] req_words = '0;
  logic [12:0] req_addr = '0;
  logic [6:0]  req_resp_len = '0;
  logic [15:0] half_cyc = 16'd1, slow_half_cyc = 16'd1;
  logic        req_ready, busy, done, vpp_en, vdd_en, pclk, dat_o, dat_oe;
  logic [63:0] resp_data;

  otp_prog_seq #(.TICKS_PER_US(TPU)) i_otp_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_words(req_words), .req_addr(req_addr),
    .req_resp_len(req_resp_len), .half_cyc(half_cyc), .slow_half_cyc(slow_half_cyc),
    .busy(busy), .done(done), .resp_data(resp_data), .vpp_en(vpp_en),
    .vdd_en(vdd_en), .pclk(pclk), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i)
  );

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  longint t_vpp_up, t_vpp_dn, t_vdd_up, t_vdd_dn, t_oe_up, t_oe_dn, t_done;
  longint t_rise, t_rise1, t_rise2, t_last_fall, t_rx_first, first_hw, last_hw, rx_hw;
  int     txn, rxn, rises, done_cnt = 0, vpp_rises;
  logic   seen_oe;
  logic   tx_bits [0:255];
  logic [63:0] rsp_pat;
  int     rsp_len_b;
  logic   pv = 0, pd = 0, pc = 0, po = 0;

  always @(negedge clk) begin
    if (vpp_en && !pv) begin t_vpp_up = cyc; vpp_rises++; end
    if (!vpp_en && pv) t_vpp_dn = cyc;
    if (vdd_en && !pd) t_vdd_up = cyc;
    if (!vdd_en && pd) t_vdd_dn = cyc;
    if (dat_oe && !po && !seen_oe) begin t_oe_up = cyc; seen_oe = 1'b1; end
    if (!dat_oe && po) t_oe_dn = cyc;
    if (pclk && !pc) begin
      rises++;
      t_rise = cyc;
      if (rises == 1) t_rise1 = cyc;
      if (rises == 2) t_rise2 = cyc;
      if (dat_oe) begin
        if (txn < 256) tx_bits[txn] = dat_o;
        txn++;
      end else begin
        rxn++;
        if (rxn == 1) t_rx_first = cyc;
        dat_i = (rxn <= rsp_len_b) ? rsp_pat[rsp_len_b - rxn] : 1'b0;
      end
    end
    if (!pclk && pc) begin
      if (rises == 1) first_hw = cyc - t_rise;
      last_hw = cyc - t_rise;
      if (!dat_oe) rx_hw = cyc - t_rise;
      t_last_fall = cyc;
    end
    if (done) begin done_cnt++; t_done = cyc; end
    pv = vpp_en; pd = vdd_en; pc = pclk; po = dat_oe;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act < exp - 1 || act > exp + 1) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (+-1)", tag, act, exp);
    end
  endtask

  function automatic longint getb(input int s, input int n);
    longint v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | longint'(tx_bits[s + i]);
    return v;
  endfunction

  task automatic clear_mon();
    txn = 0; rxn = 0; rises = 0; seen_oe = 1'b0; vpp_rises = 0;
    for (int i = 0; i < 256; i++) tx_bits[i] = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c, input logic [55:0] w, input logic [12:0] a,
                       input int len, input int h, input int sh);
    clear_mon();
    rsp_len_b = len;
    while (!req_ready) @(negedge clk);
    req_cmd = c; req_words = w; req_addr = a; req_resp_len = 7'(len);
    half_cyc = 16'(h); slow_half_cyc = 16'(sh);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic run_txn(input logic [7:0] c, input logic [55:0] w, input logic [12:0] a,
                         input int len, input int h, input int sh);
    int d0 = done_cnt;
    issue(c, w, a, len, h, sh);
    wait_done(d0);
  endtask

  task automatic check_common(input logic [7:0] c, input int h);
    chk_near("R2 vdd after vpp", t_vdd_up - t_vpp_up, D1);
    chk_near("R3 first drive after vdd", t_oe_up - t_vdd_up, D2);
    chk("R4 header bits", getb(0, HDR_N), longint'({24'hA5A5A5, c, 12'hAA1}));
    chk("R5 high phase", first_hw, h);
    chk("R5 clock period", t_rise2 - t_rise1, 2 * h);
    chk_near("R9 vdd off after last clock", t_vdd_dn - t_last_fall, D3);
    chk_near("R9 vpp off after vdd", t_vpp_dn - t_vdd_dn, D4);
    chk("R10 done at vpp off", t_done, t_vpp_dn);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R2 vpp off after reset", vpp_en, 0);
    chk("R2 vdd off after reset", vdd_en, 0);
    chk("R3 line released after reset", dat_oe, 0);
    chk("R10 done low after reset", done, 0);
  endtask

  task automatic t_no_response();
    run_txn(8'h31, '0, '0, 5, 3, 1);
    check_common(8'h31, 3);
    chk("R8 no clocks after trailer", txn, HDR_N);
    chk("R8 no capture clocks", rxn, 0);
  endtask

  task automatic t_read20();
    rsp_pat = 64'h0000_0000_000A_5C3E;
    run_txn(8'h61, '0, '0, 20, 3, 1);
    check_common(8'h61, 3);
    chk("R7 header only before turnaround", txn, HDR_N);
    chk("R7 capture clock count", rxn, 20);
    chk("R7 turnaround length", t_rx_first - t_oe_dn, 3);
    chk("R7 capture high phase", rx_hw, 3);
    chk("R7 response value", resp_data, 64'h0A_5C3E & 64'hF_FFFF);
  endtask

  task automatic t_write();
    logic [13:0] w0 = 14'h0008, w1 = 14'h3FFF, w2 = 14'h1234, w3 = 14'h2A55;
    logic [12:0] ad = 13'h1ABC;
    int zeros = 0;
    run_txn(8'h70, {w3, w2, w1, w0}, ad, 0, 2, 10);
    check_common(8'h70, 2);
    chk("R6 total driven clocks", txn, HDR_N + PAY_N + SLOW_N);
    chk("R6 word0", getb(HDR_N, 14), w0);
    chk("R6 word1", getb(HDR_N + 14, 14), w1);
    chk("R6 word2", getb(HDR_N + 28, 14), w2);
    chk("R6 word3", getb(HDR_N + 42, 14), w3);
    chk("R6 address", getb(HDR_N + 56, 13), ad);
    for (int i = 0; i < SLOW_N; i++) if (tx_bits[HDR_N + PAY_N + i] == 1'b0) zeros++;
    chk("R6 slow clocks data low", zeros, SLOW_N);
    chk("R6 slow high phase", last_hw, 10);
    chk("R6 no capture", rxn, 0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] held = resp_data;
    int d0 = done_cnt;
    int ready_seen = 0;
    issue(8'h31, '0, '0, 0, 2, 1);
    repeat (50) @(negedge clk);
    req_cmd = 8'h60; req_resp_len = 7'd8; half_cyc = 16'd5;
    req_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_ready) ready_seen++;
    end
    req_valid = 1'b0;
    chk("R1 ready low while busy", ready_seen, 0);
    wait_done(d0);
    chk("R1 command kept", getb(24, 8), 8'h31);
    chk("R1 half period kept", first_hw, 2);
    chk("R1 no capture from ignored request", rxn, 0);
    repeat (300) @(negedge clk);
    chk("R1 no extra transaction", vpp_rises, 1);
    chk("R1 one done pulse", done_cnt, d0 + 1);
    chk("R10 response held", resp_data, held);
  endtask

  task automatic t_read_zero();
    run_txn(8'h60, '0, '0, 0, 1, 1);
    check_common(8'h60, 1);
    chk("R8 read of length zero", txn, HDR_N);
    chk("R8 read of length zero capture", rxn, 0);
  endtask

  task automatic t_read_full();
    rsp_pat = 64'hC3A5_0F1E_9D2B_7764;
    run_txn(8'h60, '0, '0, 64, 1, 1);
    check_common(8'h60, 1);
    chk("R7 full capture count", rxn, 64);
    chk("R7 full turnaround", t_rx_first - t_oe_dn, 1);
    chk("R7 full response", resp_data, 64'hC3A5_0F1E_9D2B_7764);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_mon();
    rsp_pat = '0; rsp_len_b = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_response();
    t_read20();
    t_busy_ignore();
    t_write();
    t_read_zero();
    t_read_full();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule